// File: doc/BRIEF.md
# Subblock Boundary Metric Initializer

A frame is split into `NUM_SB` subblocks that are decoded at the same time, and each decoder runs one forward and one backward recursion. This unit gives every subblock the state metrics its two recursions start from. On the first iteration of a frame every boundary starts at a single uniform value. On every later iteration each subblock starts from what its neighbours ended with on the iteration before. The forward recursion of subblock k takes the final forward vector of subblock k-1. The backward recursion of subblock k takes the final backward vector of subblock k+1. The frame is tail-biting, so the indices wrap around the ends.

Each incoming end vector is normalized before it is stored: its smallest state metric is subtracted from every state. The stored vectors sit in a shadow bank. Delivered starting metrics change only on the cycle after an iteration-start pulse. When a neighbour never reported its end vector, that boundary gets the uniform value and a per-subblock miss flag is raised. An optional prolog mode tells the recursions to run an acquisition window of `ACQ_LEN` symbols, and only during the first iteration.

Top module: `sb_boundary_init`

## Requirements
- R1: One cycle after `iterStart` is sampled with `firstIter`=1, every state of every `alphaInit` and `betaInit` slice equals `INIT_VAL` (default 0), and both miss flag vectors are 0.
- R2: One cycle after `iterStart` is sampled with `firstIter`=0, the `alphaInit` slice k (bits `k*NUM_ST*MET_W` upward, state s at offset `s*MET_W`) equals the normalized `alphaEnd` slice k-1 last captured in the previous iteration.
- R3: Under the same condition, the `betaInit` slice k equals the normalized `betaEnd` slice k+1 last captured in the previous iteration.
- R4: The indices wrap. The forward start of subblock 0 comes from subblock `NUM_SB-1`, and the backward start of subblock `NUM_SB-1` comes from subblock 0.
- R5: `acqLen` reads `ACQ_LEN` (default 24) from the cycle after a first-iteration start taken with `prologEn`=1 until the next iteration start. In every other case it reads 0.
- R6: A captured vector is stored with its minimum state value subtracted from each state, so at least one state of the stored vector is 0.
- R7: `alphaInit`, `betaInit`, the miss flags and `acqLen` change only on the cycle after an `iterStart`. An end strobe sampled in the same cycle as `iterStart` belongs to the iteration that is starting.
- R8: On a later-iteration start where a neighbour has not captured a vector since the previous start, the slice fed by that neighbour is uniform `INIT_VAL`. The bit of `missFwd` (forward) or `missBwd` (backward) for that subblock reads 1 until the next start.
- R9: After reset, all starting metrics are uniform `INIT_VAL`, both miss flag vectors are 0 and `acqLen` is 0.
- R10: If a subblock strobes its end vector more than once in one iteration, the last vector is the one delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| iterStart | input | 1 | One-cycle pulse that starts an iteration |
| firstIter | input | 1 | Qualifies `iterStart` as the first iteration of a frame |
| prologEn | input | 1 | Requests an acquisition prolog for the first iteration |
| alphaEnd | input | NUM_SB*NUM_ST*MET_W | Final forward metrics of every subblock |
| alphaEndValid | input | NUM_SB | Per-subblock strobe for `alphaEnd` |
| betaEnd | input | NUM_SB*NUM_ST*MET_W | Final backward metrics of every subblock |
| betaEndValid | input | NUM_SB | Per-subblock strobe for `betaEnd` |
| alphaInit | output | NUM_SB*NUM_ST*MET_W | Forward starting metrics for every subblock |
| betaInit | output | NUM_SB*NUM_ST*MET_W | Backward starting metrics for every subblock |
| acqLen | output | ACQ_LW | Acquisition window length for the current iteration, 0 when there is none |
| missFwd | output | NUM_SB | Forward start of subblock k fell back to uniform |
| missBwd | output | NUM_SB | Backward start of subblock k fell back to uniform |

## Verification
The bench targets the wrap-around neighbours. A design that mixed up the direction of the exchange would hand subblock 0 the metrics of subblock 1, or the last subblock the metrics of its lower neighbour. It also drives end strobes during an iteration and in the same cycle as `iterStart`. A single-bank design would change the outputs mid-iteration, and a design that cleared the valid bits last would lose the coincident vector. Iterations where only some subblocks report must raise exactly the right miss bits, and a fresh first iteration must drop flags and shadow data left from the frame before. Directed vectors, such as all-maximum values and shifted ramps, check that the minimum is subtracted and not some other offset. Repeated strobes check that the last vector wins.

// File: rtl/sbinit_pkg.sv
package sbinit_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadUniform;   // first-iteration start
    logic loadNeighbour; // later-iteration start
    logic acqSet;        // prolog requested with a first-iteration start
  } sbinit_ctrl_t;
endpackage

// File: rtl/sbinit_norm.sv
module sbinit_norm #(
  parameter int NUM_ST = 8,
  parameter int MET_W  = 10
) (
  input  logic [NUM_ST*MET_W-1:0] vecIn,
  output logic [NUM_ST*MET_W-1:0] vecOut
);
  logic [MET_W-1:0] minVal;

  always_comb begin
    minVal = vecIn[MET_W-1:0];
    for (int s = 1; s < NUM_ST; s++) begin
      if (vecIn[s*MET_W +: MET_W] < minVal) minVal = vecIn[s*MET_W +: MET_W];
    end
  end

  for (genvar s = 0; s < NUM_ST; s++) begin : g_sub
    assign vecOut[s*MET_W +: MET_W] = vecIn[s*MET_W +: MET_W] - minVal;
  end
endmodule

// File: rtl/sbinit_ctrl.sv
module sbinit_ctrl
  import sbinit_pkg::*;
(
  input  logic         iterStart,
  input  logic         firstIter,
  input  logic         prologEn,
  output sbinit_ctrl_t ctrl
);
  always_comb begin
    ctrl.loadUniform   = iterStart & firstIter;
    ctrl.loadNeighbour = iterStart & ~firstIter;
    ctrl.acqSet        = iterStart & firstIter & prologEn;
  end
endmodule

// File: rtl/sbinit_dpath.sv
module sbinit_dpath
  import sbinit_pkg::*;
#(
  parameter int NUM_SB   = 4,
  parameter int NUM_ST   = 8,
  parameter int MET_W    = 10,
  parameter int INIT_VAL = 0,
  parameter int ACQ_LEN  = 24,
  parameter int ACQ_LW   = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  sbinit_ctrl_t                 ctrl,
  input  logic [NUM_SB*NUM_ST*MET_W-1:0] alphaEnd,
  input  logic [NUM_SB-1:0]            alphaEndValid,
  input  logic [NUM_SB*NUM_ST*MET_W-1:0] betaEnd,
  input  logic [NUM_SB-1:0]            betaEndValid,
  output logic [NUM_SB*NUM_ST*MET_W-1:0] alphaInit,
  output logic [NUM_SB*NUM_ST*MET_W-1:0] betaInit,
  output logic [ACQ_LW-1:0]            acqLen,
  output logic [NUM_SB-1:0]            missFwd,
  output logic [NUM_SB-1:0]            missBwd
);
  localparam int VW = NUM_ST*MET_W;
  localparam logic [VW-1:0] UNI = {NUM_ST{MET_W'(INIT_VAL)}};

  logic [NUM_SB*VW-1:0] normA, normB;
  logic [VW-1:0] shA [NUM_SB];
  logic [VW-1:0] shB [NUM_SB];
  logic [VW-1:0] actA [NUM_SB];
  logic [VW-1:0] actB [NUM_SB];
  logic [NUM_SB-1:0] shAV, shBV;
  logic [ACQ_LW-1:0] acqLenQ;
  logic anyStart;

  assign anyStart = ctrl.loadUniform | ctrl.loadNeighbour;

  for (genvar k = 0; k < NUM_SB; k++) begin : g_sb
    sbinit_norm #(.NUM_ST(NUM_ST), .MET_W(MET_W)) u_normA (
      .vecIn(alphaEnd[k*VW +: VW]), .vecOut(normA[k*VW +: VW]));
    sbinit_norm #(.NUM_ST(NUM_ST), .MET_W(MET_W)) u_normB (
      .vecIn(betaEnd[k*VW +: VW]), .vecOut(normB[k*VW +: VW]));
    assign alphaInit[k*VW +: VW] = actA[k];
    assign betaInit[k*VW +: VW]  = actB[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_SB; k++) begin
        shA[k]  <= '0;
        shB[k]  <= '0;
        actA[k] <= UNI;
        actB[k] <= UNI;
      end
      shAV    <= '0;
      shBV    <= '0;
      missFwd <= '0;
      missBwd <= '0;
      acqLenQ <= '0;
    end else begin
      for (int k = 0; k < NUM_SB; k++) begin
        // delivery from the shadow bank as it stood before this edge
        if (ctrl.loadUniform) begin
          actA[k]    <= UNI;
          actB[k]    <= UNI;
          missFwd[k] <= 1'b0;
          missBwd[k] <= 1'b0;
        end else if (ctrl.loadNeighbour) begin
          if (shAV[(k+NUM_SB-1)%NUM_SB]) begin
            actA[k]    <= shA[(k+NUM_SB-1)%NUM_SB];
            missFwd[k] <= 1'b0;
          end else begin
            actA[k]    <= UNI;
            missFwd[k] <= 1'b1;
          end
          if (shBV[(k+1)%NUM_SB]) begin
            actB[k]    <= shB[(k+1)%NUM_SB];
            missBwd[k] <= 1'b0;
          end else begin
            actB[k]    <= UNI;
            missBwd[k] <= 1'b1;
          end
        end
        // capture into the shadow bank; a strobe beats the start clear
        if (alphaEndValid[k]) begin
          shA[k]  <= normA[k*VW +: VW];
          shAV[k] <= 1'b1;
        end else if (anyStart) begin
          shAV[k] <= 1'b0;
        end
        if (betaEndValid[k]) begin
          shB[k]  <= normB[k*VW +: VW];
          shBV[k] <= 1'b1;
        end else if (anyStart) begin
          shBV[k] <= 1'b0;
        end
      end
      if (anyStart) acqLenQ <= ctrl.acqSet ? ACQ_LW'(ACQ_LEN) : '0;
    end
  end

  assign acqLen = acqLenQ;
endmodule

// File: rtl/sb_boundary_init.sv
module sb_boundary_init
  import sbinit_pkg::*;
#(
  parameter int NUM_SB   = 4,
  parameter int NUM_ST   = 8,
  parameter int MET_W    = 10,
  parameter int INIT_VAL = 0,
  parameter int ACQ_LEN  = 24,
  parameter int ACQ_LW   = $clog2(ACQ_LEN+1)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           iterStart,
  input  logic                           firstIter,
  input  logic                           prologEn,
  input  logic [NUM_SB*NUM_ST*MET_W-1:0] alphaEnd,
  input  logic [NUM_SB-1:0]              alphaEndValid,
  input  logic [NUM_SB*NUM_ST*MET_W-1:0] betaEnd,
  input  logic [NUM_SB-1:0]              betaEndValid,
  output logic [NUM_SB*NUM_ST*MET_W-1:0] alphaInit,
  output logic [NUM_SB*NUM_ST*MET_W-1:0] betaInit,
  output logic [ACQ_LW-1:0]              acqLen,
  output logic [NUM_SB-1:0]              missFwd,
  output logic [NUM_SB-1:0]              missBwd
);
  sbinit_ctrl_t ctrl;

  sbinit_ctrl u_ctrl (
    .iterStart(iterStart), .firstIter(firstIter), .prologEn(prologEn), .ctrl(ctrl));

  sbinit_dpath #(
    .NUM_SB(NUM_SB), .NUM_ST(NUM_ST), .MET_W(MET_W),
    .INIT_VAL(INIT_VAL), .ACQ_LEN(ACQ_LEN), .ACQ_LW(ACQ_LW)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .alphaEnd(alphaEnd), .alphaEndValid(alphaEndValid),
    .betaEnd(betaEnd), .betaEndValid(betaEndValid),
    .alphaInit(alphaInit), .betaInit(betaInit), .acqLen(acqLen),
    .missFwd(missFwd), .missBwd(missBwd));
endmodule

// File: rtl/sbinit_chk.sv
module sbinit_chk #(
  parameter int NUM_SB   = 4,
  parameter int NUM_ST   = 8,
  parameter int MET_W    = 10,
  parameter int INIT_VAL = 0,
  parameter int ACQ_LEN  = 24,
  parameter int ACQ_LW   = 5
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           iterStart,
  input logic                           firstIter,
  input logic                           prologEn,
  input logic [NUM_SB*NUM_ST*MET_W-1:0] alphaInit,
  input logic [NUM_SB*NUM_ST*MET_W-1:0] betaInit,
  input logic [ACQ_LW-1:0]              acqLen,
  input logic [NUM_SB-1:0]              missFwd,
  input logic [NUM_SB-1:0]              missBwd
);
  localparam int VW = NUM_ST*MET_W;
  localparam logic [VW-1:0] UNI = {NUM_ST{MET_W'(INIT_VAL)}};
  localparam logic [NUM_SB*VW-1:0] UNI_ALL = {NUM_SB{UNI}};

  function automatic logic hasZero(input logic [VW-1:0] v);
    logic z;
    z = 1'b0;
    for (int s = 0; s < NUM_ST; s++) if (v[s*MET_W +: MET_W] == '0) z = 1'b1;
    return z;
  endfunction

  AST_FIRST_UNIFORM: assert property (@(posedge clk) disable iff (!rstN)
    iterStart && firstIter |=> alphaInit == UNI_ALL && betaInit == UNI_ALL
      && missFwd == '0 && missBwd == '0); // R1

  AST_HOLD_MID_ITER: assert property (@(posedge clk) disable iff (!rstN)
    !iterStart |=> $stable(alphaInit) && $stable(betaInit) && $stable(missFwd)
      && $stable(missBwd) && $stable(acqLen)); // R7

  AST_ACQ_FIRST_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    iterStart |=> acqLen == ($past(firstIter && prologEn) ? ACQ_LW'(ACQ_LEN) : '0)); // R5

  for (genvar k = 0; k < NUM_SB; k++) begin : g_k
    AST_MISS_FWD_UNIFORM: assert property (@(posedge clk) disable iff (!rstN)
      missFwd[k] |-> alphaInit[k*VW +: VW] == UNI); // R8
    AST_MISS_BWD_UNIFORM: assert property (@(posedge clk) disable iff (!rstN)
      missBwd[k] |-> betaInit[k*VW +: VW] == UNI); // R8
    if (INIT_VAL == 0) begin : g_zero
      AST_NORM_HAS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
        hasZero(alphaInit[k*VW +: VW]) && hasZero(betaInit[k*VW +: VW])); // R6
    end
  end
endmodule

bind sb_boundary_init sbinit_chk #(
  .NUM_SB(NUM_SB), .NUM_ST(NUM_ST), .MET_W(MET_W),
  .INIT_VAL(INIT_VAL), .ACQ_LEN(ACQ_LEN), .ACQ_LW(ACQ_LW)
) u_chk (
  .clk(clk), .rstN(rstN), .iterStart(iterStart), .firstIter(firstIter),
  .prologEn(prologEn), .alphaInit(alphaInit), .betaInit(betaInit),
  .acqLen(acqLen), .missFwd(missFwd), .missBwd(missBwd));

// File: tb/sb_boundary_init_bench.sv
module sb_boundary_init_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P  = 4;
  localparam int S  = 8;
  localparam int W  = 10;
  localparam int AL = 24;
  localparam int LW = $clog2(AL+1);
  localparam int VW = S*W;
  localparam int FW = P*VW;
  localparam logic [VW-1:0] UNI = '0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic iterStart = 1'b0, firstIter = 1'b0, prologEn = 1'b0;
  logic [FW-1:0] alphaEnd = '0, betaEnd = '0;
  logic [P-1:0] alphaEndValid = '0, betaEndValid = '0;
  logic [FW-1:0] alphaInit, betaInit;
  logic [LW-1:0] acqLen;
  logic [P-1:0] missFwd, missBwd;

  int nChecks = 0, nFails = 0;

  logic [VW-1:0] mA [P];
  logic [VW-1:0] mB [P];
  logic [P-1:0]  vA, vB;
  logic [VW-1:0] eA [P];
  logic [VW-1:0] eB [P];
  logic [P-1:0]  eMF, eMB;
  logic [LW-1:0] eAcq;

  always #(CLK_PERIOD/2) clk = ~clk;

  sb_boundary_init #(.NUM_SB(P), .NUM_ST(S), .MET_W(W), .INIT_VAL(0), .ACQ_LEN(AL)) u_sb_boundary_init (
    .clk(clk), .rstN(rstN), .iterStart(iterStart), .firstIter(firstIter), .prologEn(prologEn),
    .alphaEnd(alphaEnd), .alphaEndValid(alphaEndValid), .betaEnd(betaEnd),
    .betaEndValid(betaEndValid), .alphaInit(alphaInit), .betaInit(betaInit),
    .acqLen(acqLen), .missFwd(missFwd), .missBwd(missBwd));

  function automatic logic [VW-1:0] normVec(input logic [VW-1:0] v);
    logic [W-1:0] mn;
    logic [VW-1:0] r;
    mn = v[W-1:0];
    for (int s = 1; s < S; s++) if (v[s*W +: W] < mn) mn = v[s*W +: W];
    for (int s = 0; s < S; s++) r[s*W +: W] = v[s*W +: W] - mn;
    return r;
  endfunction

  function automatic logic [FW-1:0] randFrame();
    logic [FW-1:0] f;
    for (int i = 0; i < P*S; i++) f[i*W +: W] = W'($urandom);
    return f;
  endfunction

  task automatic chk(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp, input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    logic [FW-1:0] xa, xb;
    for (int k = 0; k < P; k++) begin
      xa[k*VW +: VW] = eA[k];
      xb[k*VW +: VW] = eB[k];
    end
    chk(tag, alphaInit, xa, "alphaInit");
    chk(tag, betaInit, xb, "betaInit");
    chk(tag, FW'({missBwd, missFwd}), FW'({eMB, eMF}), "miss flags");
    chk(tag, FW'(acqLen), FW'(eAcq), "acqLen");
  endtask

  // drive at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic cycle(input logic [P-1:0] av, input logic [FW-1:0] ad,
                       input logic [P-1:0] bv, input logic [FW-1:0] bd,
                       input bit is, input bit fi, input bit pe, input string tag);
    alphaEndValid = av; alphaEnd = ad; betaEndValid = bv; betaEnd = bd;
    iterStart = is; firstIter = fi; prologEn = pe;
    @(negedge clk);
    alphaEndValid = '0; betaEndValid = '0; iterStart = 1'b0; firstIter = 1'b0; prologEn = 1'b0;
    if (is) begin
      for (int k = 0; k < P; k++) begin
        if (fi) begin
          eA[k] = UNI; eB[k] = UNI; eMF[k] = 1'b0; eMB[k] = 1'b0;
        end else begin
          eA[k]  = vA[(k+P-1)%P] ? mA[(k+P-1)%P] : UNI;
          eMF[k] = !vA[(k+P-1)%P];
          eB[k]  = vB[(k+1)%P] ? mB[(k+1)%P] : UNI;
          eMB[k] = !vB[(k+1)%P];
        end
      end
      eAcq = (fi && pe) ? LW'(AL) : '0;
      vA = '0; vB = '0;
    end
    for (int k = 0; k < P; k++) begin
      if (av[k]) begin mA[k] = normVec(ad[k*VW +: VW]); vA[k] = 1'b1; end
      if (bv[k]) begin mB[k] = normVec(bd[k*VW +: VW]); vB[k] = 1'b1; end
    end
    checkAll(tag);
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [FW-1:0] fa, fb, ramp;
    void'($urandom(32'd4711));
    for (int k = 0; k < P; k++) begin
      mA[k] = '0; mB[k] = '0; eA[k] = UNI; eB[k] = UNI;
    end
    vA = '0; vB = '0; eMF = '0; eMB = '0; eAcq = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R9");

    // first iteration without prolog
    cycle('0, '0, '0, '0, 1, 1, 0, "R1");
    // end strobes in mid-iteration must not move the outputs
    fa = randFrame(); fb = randFrame();
    cycle('1, fa, '1, fb, 0, 0, 0, "R7");
    cycle('0, '0, '0, '0, 0, 0, 0, "R7");
    // exchange with wrap
    cycle('0, '0, '0, '0, 1, 0, 0, "R2");
    chk("R4", FW'(alphaInit[0 +: VW]), FW'(normVec(fa[(P-1)*VW +: VW])), "sb0 forward from last");
    chk("R4", FW'(betaInit[(P-1)*VW +: VW]), FW'(normVec(fb[0 +: VW])), "last backward from sb0");
    chk("R3", FW'(betaInit[VW +: VW]), FW'(normVec(fb[2*VW +: VW])), "sb1 backward from sb2");

    // normalization corner cases: all maximum, and a ramp offset by 5
    ramp = '0;
    for (int i = 0; i < P*S; i++) ramp[i*W +: W] = W'(5 + (i % S));
    cycle('1, {FW{1'b1}}, '1, ramp, 0, 0, 0, "R6");
    cycle('0, '0, '0, '0, 1, 0, 0, "R6");
    chk("R6", FW'(alphaInit[VW +: VW]), FW'(0), "all-max vector normalized");
    chk("R6", FW'(betaInit[0 +: VW][W-1:0]), FW'(0), "ramp minimum state");

    // partial report: only subblocks 0 and 2 send alpha, only 1 sends beta
    cycle(4'b0101, randFrame(), 4'b0010, randFrame(), 0, 0, 0, "R8");
    cycle('0, '0, '0, '0, 1, 0, 0, "R8");
    // nothing reported at all
    cycle('0, '0, '0, '0, 1, 0, 0, "R8");

    // strobe coincident with the start belongs to the new iteration
    fa = randFrame();
    cycle('1, fa, '1, fa, 1, 0, 0, "R7");
    cycle('0, '0, '0, '0, 1, 0, 0, "R7");

    // repeated strobes, last one wins
    cycle('1, randFrame(), '1, randFrame(), 0, 0, 0, "R10");
    cycle('1, randFrame(), '1, randFrame(), 0, 0, 0, "R10");
    cycle('0, '0, '0, '0, 1, 0, 0, "R10");

    // new frame with prolog: stale shadow and flags dropped, window applied once
    cycle('1, randFrame(), '0, '0, 0, 0, 0, "R1");
    cycle('0, '0, '0, '0, 1, 1, 1, "R5");
    cycle('1, randFrame(), '1, randFrame(), 0, 0, 0, "R5");
    cycle('0, '0, '0, '0, 1, 0, 0, "R5");

    // random iterations
    for (int it = 0; it < 300; it++) begin
      int nMid;
      nMid = 1 + int'($urandom % 4);
      for (int c = 0; c < nMid; c++)
        cycle(P'($urandom), randFrame(), P'($urandom), randFrame(), 0, 0, 0, "R2");
      cycle(P'($urandom), randFrame(), P'($urandom), randFrame(), 1,
            ($urandom % 16) == 0, $urandom % 2, "R3");
    end

    finishRun();
  end
endmodule